// File: doc/BRIEF.md
# Virtual Interrupt Acknowledge and End-of-Interrupt Engine

This block keeps a small bank of list entries, each a 64-bit word describing one virtual interrupt, and serves four guest operations on it: acknowledge, peek at the best pending interrupt, end-of-interrupt (priority drop plus optional deactivate), and a separate deactivate. Every operation starts with a one-cycle request strobe. The engine then walks the entries in use, one per clock. It records the best pending candidate and the first active entry whose ID matches the request. After the walk it decides the result, updates at most one entry, and returns an ID with a one-cycle done pulse.

Active-priority bookkeeping lives outside the block. The engine reads the current running priority from a tracker port. On a successful acknowledge it emits a set pulse carrying the preemption level and group. On every end-of-interrupt it emits a drop pulse and reads back, in the same cycle, the level that the tracker dropped.

Entry layout, which software and the engine both rely on: bits 31:0 hold the virtual ID, bits 55:48 the priority (lower value means more urgent), bit 60 the group, and bits 63:62 the state. In the state field 01 means pending, 10 active and 11 pending plus active. The preemption level of a priority is the priority with its low bits cleared: bpr0+1 bits for group 0, bpr1 bits for group 1. The spurious ID is 1023, the last shared-peripheral ID is 1019, and message-based interrupts start at 8192.

Top module: `virq_ack_engine`

## Requirements
- R1: During the walk only entries below `lr_used` whose state field equals 01 exactly are candidates. Entries in state 10 or 11, and entries at or above `lr_used`, are never chosen.
- R2: A group-0 entry is not a candidate while `grp0_en` is low, and a group-1 entry is not a candidate while `grp1_en` is low.
- R3: The walk starts from a best priority of 0xFF and takes an entry only when its priority is strictly below the best so far. Among equal priorities the lowest index wins, and a priority of 0xFF can never be chosen.
- R4: Acknowledge returns 1023 and changes no entry when there is no candidate, when the candidate's group differs from `req_grp`, when `prio_mask` is at most the candidate priority, or when `run_prio` is at most the candidate's preemption level.
- R5: A successful acknowledge returns the candidate ID and clears its state field. It sets the state to active (10) only if the ID is at most 1019, and leaves it at 00 otherwise. In the same cycle as done it pulses `apr_set` with the preemption level and the requested group.
- R6: Every end-of-interrupt pulses `apr_drop` once. It deactivates nothing when the ID is at least 8192 or `eoi_mode` is 1.
- R7: An end-of-interrupt with `eoi_mode` 0 and an ID below 8192 clears the active bit (bit 63) of the first active entry with that ID, but only when the entry's group equals `req_grp` and its preemption level equals `drop_prio`. When no such active entry exists, `eoi_count` is incremented by one instead, wrapping at its width.
- R8: A deactivate request does nothing when `eoi_mode` is 0 or the ID is at least 8192. Otherwise it clears bit 63 of the first matching active entry, or increments `eoi_count` when there is none.
- R9: Peek returns the candidate ID, or 1023 when there is no candidate or its group differs from `req_grp`. It modifies no entry and no counter.
- R10: `rsp_done` is high for exactly one cycle, NUM_LR+1 clock edges after the edge that accepts the request. Opcodes: 0 acknowledge, 1 peek, 2 end-of-interrupt, 3 deactivate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle request strobe, taken while idle |
| req_op | input | 2 | Operation code |
| req_grp | input | 1 | Group of the requesting operation |
| req_id | input | 32 | Interrupt ID for end-of-interrupt and deactivate |
| grp0_en | input | 1 | Group 0 enable |
| grp1_en | input | 1 | Group 1 enable |
| eoi_mode | input | 1 | 0: end-of-interrupt also deactivates; 1: separate deactivate |
| prio_mask | input | 8 | Priority mask |
| bpr0 | input | 3 | Binary point, group 0 |
| bpr1 | input | 3 | Binary point, group 1 |
| lr_used | input | IDX_W+1 | Number of entries in use |
| lr_wr_en | input | 1 | Entry write strobe |
| lr_wr_idx | input | IDX_W | Entry write index |
| lr_wr_data | input | 64 | Entry write data |
| lr_rd_idx | input | IDX_W | Entry read index |
| lr_rd_data | output | 64 | Entry read data |
| run_prio | input | 8 | Running priority from the tracker |
| drop_prio | input | 8 | Level dropped by the tracker during `apr_drop` |
| apr_set | output | 1 | Mark an active level in the tracker |
| apr_set_lvl | output | 8 | Preemption level to mark |
| apr_set_grp | output | 1 | Group of the level to mark |
| apr_drop | output | 1 | Drop the highest active level |
| rsp_done | output | 1 | Operation complete |
| rsp_id | output | 32 | Result ID (request ID echoed for end-of-interrupt and deactivate) |
| eoi_count | output | EOI_CNT_W | Count of end-of-interrupts with no matching entry |

## Verification
The hardest case to reach is an end-of-interrupt in mode 0 that finds an active entry and is still refused because the tracker's dropped level differs from the entry's preemption level. Random IDs and levels almost never line up that way. The stimulus therefore draws end-of-interrupt IDs mostly from entries already in the bank and, half of the time, presents a dropped level equal to the preemption level of a random entry. Random values cover the mismatch side. Directed cases cover tie-breaking on equal priority, entries in state 11, entries above the used count, and message-based IDs.

// File: rtl/virq_pkg.sv
package virq_pkg;

   localparam int LR_W       = 64;
   localparam int VID_W      = 32;
   localparam int PRIO_W     = 8;
   localparam int ST_HI      = 63;
   localparam int ST_LO      = 62;
   localparam int GRP_BIT    = 60;
   localparam int PRIO_HI    = 55;
   localparam int PRIO_LO    = 48;

   typedef enum logic [1:0] {
      OP_ACK   = 2'd0,
      OP_PEEK  = 2'd1,
      OP_EOI   = 2'd2,
      OP_DEACT = 2'd3
   } virq_op_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SCAN   = 2'd1,
      ST_FINISH = 2'd2
   } virq_fsm_e;

   function automatic logic [VID_W-1:0] lr_vid(input logic [LR_W-1:0] e);
      return e[VID_W-1:0];
   endfunction

   function automatic logic [PRIO_W-1:0] lr_prio(input logic [LR_W-1:0] e);
      return e[PRIO_HI:PRIO_LO];
   endfunction

   function automatic logic lr_grp(input logic [LR_W-1:0] e);
      return e[GRP_BIT];
   endfunction

   function automatic logic [1:0] lr_state(input logic [LR_W-1:0] e);
      return e[ST_HI:ST_LO];
   endfunction

   // Preemption level: clear the sub-priority bits selected by the group's binary point
   function automatic logic [PRIO_W-1:0] pre_level(input logic [PRIO_W-1:0] p,
                                                  input logic g,
                                                  input logic [2:0] b0,
                                                  input logic [2:0] b1);
      logic [3:0] sh;
      logic [PRIO_W-1:0] msk;
      sh  = g ? {1'b0, b1} : ({1'b0, b0} + 4'd1);
      msk = {PRIO_W{1'b1}} << sh;
      return p & msk;
   endfunction

endpackage

// File: rtl/virq_lr_bank.sv
module virq_lr_bank
   import virq_pkg::*;
#(
   parameter int NUM_LR = 16,
   parameter int IDX_W  = (NUM_LR > 1) ? $clog2(NUM_LR) : 1,
   parameter logic [31:0] MAX_SPI_ID = 32'd1019
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_we,
   input  logic [IDX_W-1:0] ext_idx,
   input  logic [LR_W-1:0]  ext_data,
   input  logic             eng_we,
   input  logic [IDX_W-1:0] eng_idx,
   input  logic [LR_W-1:0]  eng_data,
   input  logic [IDX_W-1:0] scan_idx,
   output logic [LR_W-1:0]  scan_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [LR_W-1:0]  rd_data
);

   logic [LR_W-1:0] mem [NUM_LR];

   for (genvar g = 0; g < NUM_LR; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[g] <= '0;
         else if (eng_we && (eng_idx == IDX_W'(g)))
            mem[g] <= eng_data;
         else if (ext_we && (ext_idx == IDX_W'(g)))
            mem[g] <= ext_data;
      end
   end

   assign scan_data = (32'(scan_idx) < NUM_LR) ? mem[scan_idx] : '0;
   assign rd_data   = (32'(rd_idx)   < NUM_LR) ? mem[rd_idx]   : '0;

   // R5: engine never leaves an interrupt above the shared range in active state
   assert_lpi_no_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_we && (lr_vid(eng_data) > MAX_SPI_ID)) |-> !eng_data[ST_HI]);

endmodule

// File: rtl/virq_scan.sv
module virq_scan
   import virq_pkg::*;
#(
   parameter int NUM_LR = 16,
   parameter int IDX_W  = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             step,
   input  logic [IDX_W-1:0] idx,
   input  logic [LR_W-1:0]  entry,
   input  logic [IDX_W:0]   used,
   input  logic             g0_en,
   input  logic             g1_en,
   input  logic [VID_W-1:0] match_id,
   output logic             cand_found,
   output logic [IDX_W-1:0] cand_idx,
   output logic [LR_W-1:0]  cand_entry,
   output logic             act_found,
   output logic [IDX_W-1:0] act_idx,
   output logic [LR_W-1:0]  act_entry
);

   logic [PRIO_W-1:0] best_prio;
   logic in_use, grp_ok, is_cand, is_match;

   always_comb begin
      in_use   = {1'b0, idx} < used;
      grp_ok   = lr_grp(entry) ? g1_en : g0_en;
      is_cand  = in_use && (lr_state(entry) == 2'b01) && grp_ok
                 && (lr_prio(entry) < best_prio);
      is_match = in_use && !act_found && entry[ST_HI]
                 && (lr_vid(entry) == match_id);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         best_prio  <= '1;
         cand_found <= 1'b0;
         cand_idx   <= '0;
         cand_entry <= '0;
         act_found  <= 1'b0;
         act_idx    <= '0;
         act_entry  <= '0;
      end else if (start) begin
         best_prio  <= '1;
         cand_found <= 1'b0;
         act_found  <= 1'b0;
      end else if (step) begin
         if (is_cand) begin
            best_prio  <= lr_prio(entry);
            cand_found <= 1'b1;
            cand_idx   <= idx;
            cand_entry <= entry;
         end
         if (is_match) begin
            act_found <= 1'b1;
            act_idx   <= idx;
            act_entry <= entry;
         end
      end
   end

   // R3: best priority only moves downward during a walk
   assert_best_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (best_prio <= $past(best_prio)));

   // R1: a recorded candidate was pending-only when taken
   assert_cand_pending_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (step && is_cand) |=> (lr_state(cand_entry) == 2'b01));

endmodule

// File: rtl/virq_ack_engine.sv
module virq_ack_engine
   import virq_pkg::*;
#(
   parameter int NUM_LR    = 16,
   parameter int EOI_CNT_W = 5,
   parameter logic [31:0] SPUR_ID    = 32'd1023,
   parameter logic [31:0] MAX_SPI_ID = 32'd1019,
   parameter logic [31:0] LPI_BASE   = 32'd8192,
   localparam int IDX_W = (NUM_LR > 1) ? $clog2(NUM_LR) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [1:0]           req_op,
   input  logic                 req_grp,
   input  logic [31:0]          req_id,
   input  logic                 grp0_en,
   input  logic                 grp1_en,
   input  logic                 eoi_mode,
   input  logic [7:0]           prio_mask,
   input  logic [2:0]           bpr0,
   input  logic [2:0]           bpr1,
   input  logic [IDX_W:0]       lr_used,
   input  logic                 lr_wr_en,
   input  logic [IDX_W-1:0]     lr_wr_idx,
   input  logic [63:0]          lr_wr_data,
   input  logic [IDX_W-1:0]     lr_rd_idx,
   output logic [63:0]          lr_rd_data,
   input  logic [7:0]           run_prio,
   input  logic [7:0]           drop_prio,
   output logic                 apr_set,
   output logic [7:0]           apr_set_lvl,
   output logic                 apr_set_grp,
   output logic                 apr_drop,
   output logic                 rsp_done,
   output logic [31:0]          rsp_id,
   output logic [EOI_CNT_W-1:0] eoi_count
);

   if (NUM_LR < 1 || NUM_LR > 16) begin : g_bad_num
      $error("NUM_LR must lie in 1..16");
   end
   if (LPI_BASE <= MAX_SPI_ID) begin : g_bad_ids
      $error("LPI_BASE must exceed MAX_SPI_ID");
   end
   if (EOI_CNT_W < 1) begin : g_bad_cnt
      $error("EOI_CNT_W must be positive");
   end

   virq_fsm_e         state;
   virq_op_e          op_q;
   logic              grp_q;
   logic [VID_W-1:0]  id_q;
   logic [IDX_W-1:0]  scan_idx;
   logic [LR_W-1:0]   scan_data;

   logic              start, step;
   logic              cand_found, act_found;
   logic [IDX_W-1:0]  cand_idx, act_idx;
   logic [LR_W-1:0]   cand_entry, act_entry;

   logic              eng_we;
   logic [IDX_W-1:0]  eng_idx;
   logic [LR_W-1:0]   eng_data;
   logic [VID_W-1:0]  res_id;
   logic              set_now, cnt_inc;
   logic [PRIO_W-1:0] cand_lvl, act_lvl;
   logic              ack_ok, id_lpi;

   assign start = (state == ST_IDLE) && req_valid;
   assign step  = (state == ST_SCAN);

   virq_lr_bank #(.NUM_LR(NUM_LR), .IDX_W(IDX_W), .MAX_SPI_ID(MAX_SPI_ID)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_we    (lr_wr_en),
      .ext_idx   (lr_wr_idx),
      .ext_data  (lr_wr_data),
      .eng_we    (eng_we),
      .eng_idx   (eng_idx),
      .eng_data  (eng_data),
      .scan_idx  (scan_idx),
      .scan_data (scan_data),
      .rd_idx    (lr_rd_idx),
      .rd_data   (lr_rd_data)
   );

   virq_scan #(.NUM_LR(NUM_LR), .IDX_W(IDX_W)) u_scan (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .step       (step),
      .idx        (scan_idx),
      .entry      (scan_data),
      .used       (lr_used),
      .g0_en      (grp0_en),
      .g1_en      (grp1_en),
      .match_id   (id_q),
      .cand_found (cand_found),
      .cand_idx   (cand_idx),
      .cand_entry (cand_entry),
      .act_found  (act_found),
      .act_idx    (act_idx),
      .act_entry  (act_entry)
   );

   // Decision logic, evaluated in the finishing cycle
   always_comb begin
      cand_lvl = pre_level(lr_prio(cand_entry), grp_q, bpr0, bpr1);
      act_lvl  = pre_level(lr_prio(act_entry), grp_q, bpr0, bpr1);
      id_lpi   = (id_q >= LPI_BASE);
      ack_ok   = cand_found && (lr_grp(cand_entry) == grp_q)
                 && (prio_mask > lr_prio(cand_entry)) && (run_prio > cand_lvl);
      eng_we   = 1'b0;
      eng_idx  = cand_idx;
      eng_data = cand_entry;
      res_id   = id_q;
      set_now  = 1'b0;
      cnt_inc  = 1'b0;
      if (state == ST_FINISH) begin
         unique case (op_q)
            OP_ACK: begin
               res_id = SPUR_ID;
               if (ack_ok) begin
                  res_id                = lr_vid(cand_entry);
                  eng_we                = 1'b1;
                  eng_data[ST_HI:ST_LO] = (lr_vid(cand_entry) <= MAX_SPI_ID) ? 2'b10 : 2'b00;
                  set_now               = 1'b1;
               end
            end
            OP_PEEK: begin
               res_id = (cand_found && (lr_grp(cand_entry) == grp_q))
                        ? lr_vid(cand_entry) : SPUR_ID;
            end
            OP_EOI: begin
               if (!id_lpi && !eoi_mode) begin
                  if (!act_found)
                     cnt_inc = 1'b1;
                  else if ((lr_grp(act_entry) == grp_q) && (act_lvl == drop_prio)) begin
                     eng_we          = 1'b1;
                     eng_idx         = act_idx;
                     eng_data        = act_entry;
                     eng_data[ST_HI] = 1'b0;
                  end
               end
            end
            OP_DEACT: begin
               if (!id_lpi && eoi_mode) begin
                  if (!act_found)
                     cnt_inc = 1'b1;
                  else begin
                     eng_we          = 1'b1;
                     eng_idx         = act_idx;
                     eng_data        = act_entry;
                     eng_data[ST_HI] = 1'b0;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign apr_drop = (state == ST_FINISH) && (op_q == OP_EOI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         op_q        <= OP_ACK;
         grp_q       <= 1'b0;
         id_q        <= '0;
         scan_idx    <= '0;
         rsp_done    <= 1'b0;
         rsp_id      <= '0;
         apr_set     <= 1'b0;
         apr_set_lvl <= '0;
         apr_set_grp <= 1'b0;
         eoi_count   <= '0;
      end else begin
         rsp_done <= 1'b0;
         apr_set  <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  op_q     <= virq_op_e'(req_op);
                  grp_q    <= req_grp;
                  id_q     <= req_id;
                  scan_idx <= '0;
                  state    <= ST_SCAN;
               end
            end
            ST_SCAN: begin
               if (32'(scan_idx) == NUM_LR - 1)
                  state <= ST_FINISH;
               else
                  scan_idx <= scan_idx + 1'b1;
            end
            ST_FINISH: begin
               rsp_done    <= 1'b1;
               rsp_id      <= res_id;
               apr_set     <= set_now;
               apr_set_lvl <= cand_lvl;
               apr_set_grp <= grp_q;
               if (cnt_inc)
                  eoi_count <= eoi_count + 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R10: done lasts a single cycle
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   // R7: the miss counter only ever advances by one
   assert_eoi_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_count != $past(eoi_count)) |-> (eoi_count == $past(eoi_count) + 1'b1));

   // R6: a drop is always followed by completion
   assert_drop_then_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      apr_drop |=> rsp_done);

   // R9: peek never writes an entry
   assert_peek_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_FINISH) && (op_q == OP_PEEK)) |-> !eng_we);

   // R5: a tracker set accompanies a completed acknowledge with a real ID
   assert_set_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      apr_set |-> (rsp_done && (rsp_id != SPUR_ID)));

endmodule

// File: tb/virq_ack_engine_tb.sv
module virq_ack_engine_tb;

   localparam int N    = 16;
   localparam int IW   = 4;
   localparam int CW   = 5;
   localparam int SPUR = 1023;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = '0;
   logic          req_grp = 1'b0;
   logic [31:0]   req_id = '0;
   logic          grp0_en = 1'b1, grp1_en = 1'b1, eoi_mode = 1'b0;
   logic [7:0]    prio_mask = 8'hFF;
   logic [2:0]    bpr0 = '0, bpr1 = '0;
   logic [IW:0]   lr_used = '0;
   logic          lr_wr_en = 1'b0;
   logic [IW-1:0] lr_wr_idx = '0;
   logic [63:0]   lr_wr_data = '0;
   logic [IW-1:0] lr_rd_idx = '0;
   logic [63:0]   lr_rd_data;
   logic [7:0]    run_prio = 8'hFF, drop_prio = 8'h00;
   logic          apr_set, apr_set_grp, apr_drop, rsp_done;
   logic [7:0]    apr_set_lvl;
   logic [31:0]   rsp_id;
   logic [CW-1:0] eoi_count;

   int errors = 0, checks = 0;
   logic [63:0] model [N];
   int m_cnt = 0;
   int set_cnt = 0, drop_cnt = 0;
   logic [7:0] set_lvl_seen;
   logic set_grp_seen;

   always #10 clk = ~clk;

   virq_ack_engine #(.NUM_LR(N), .EOI_CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_grp(req_grp), .req_id(req_id), .grp0_en(grp0_en), .grp1_en(grp1_en),
      .eoi_mode(eoi_mode), .prio_mask(prio_mask), .bpr0(bpr0), .bpr1(bpr1),
      .lr_used(lr_used), .lr_wr_en(lr_wr_en), .lr_wr_idx(lr_wr_idx),
      .lr_wr_data(lr_wr_data), .lr_rd_idx(lr_rd_idx), .lr_rd_data(lr_rd_data),
      .run_prio(run_prio), .drop_prio(drop_prio), .apr_set(apr_set),
      .apr_set_lvl(apr_set_lvl), .apr_set_grp(apr_set_grp), .apr_drop(apr_drop),
      .rsp_done(rsp_done), .rsp_id(rsp_id), .eoi_count(eoi_count));

   always @(negedge clk) begin
      if (apr_set) begin
         set_cnt++;
         set_lvl_seen = apr_set_lvl;
         set_grp_seen = apr_set_grp;
      end
      if (apr_drop) drop_cnt++;
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] tb_pre(input logic [7:0] p, input logic g);
      int sh;
      sh = g ? int'(bpr1) : int'(bpr0) + 1;
      return 8'((255 << sh) & 255) & p;
   endfunction

   task automatic load(input int i, input logic [63:0] d);
      @(negedge clk);
      lr_wr_en = 1'b1; lr_wr_idx = IW'(i); lr_wr_data = d;
      @(negedge clk);
      lr_wr_en = 1'b0;
      model[i] = d;
   endtask

   function automatic logic [63:0] mk(input logic [31:0] vid, input logic [7:0] pr,
                                      input logic g, input logic [1:0] st);
      logic [63:0] d;
      d = {$urandom, $urandom};
      d[31:0] = vid; d[55:48] = pr; d[60] = g; d[63:62] = st;
      return d;
   endfunction

   task automatic do_op(input logic [1:0] op, input logic g, input logic [31:0] id, input string tag_in);
      string tag;
      bit found, afound, ok;
      int bi, ai, lat;
      logic [7:0] bp;
      logic [31:0] exp_id;
      int exp_set, exp_drop;
      logic [7:0] exp_lvl;
      bit mism;
      tag = tag_in;
      if (tag == "") tag = (op == 0) ? "R4" : (op == 1) ? "R9" : (op == 2) ? "R7" : "R8";
      found = 0; bp = 8'hFF; bi = 0; afound = 0; ai = 0;
      for (int i = 0; i < int'(lr_used); i++) begin
         if (model[i][63:62] == 2'b01 && (model[i][60] ? grp1_en : grp0_en)
             && model[i][55:48] < bp) begin
            bp = model[i][55:48]; bi = i; found = 1;
         end
         if (!afound && model[i][63] && model[i][31:0] == id) begin
            afound = 1; ai = i;
         end
      end
      exp_id = id; exp_set = 0; exp_drop = 0; exp_lvl = tb_pre(bp, g);
      case (op)
         2'd0: begin
            ok = found && model[bi][60] == g && prio_mask > bp && run_prio > exp_lvl;
            exp_id = ok ? model[bi][31:0] : SPUR;
            if (ok) begin
               exp_set = 1;
               model[bi][63:62] = (model[bi][31:0] <= 1019) ? 2'b10 : 2'b00;
            end
         end
         2'd1: exp_id = (found && model[bi][60] == g) ? model[bi][31:0] : SPUR;
         2'd2: begin
            exp_drop = 1;
            if (id < 8192 && !eoi_mode) begin
               if (!afound) m_cnt = (m_cnt + 1) % (1 << CW);
               else if (model[ai][60] == g && tb_pre(model[ai][55:48], g) == drop_prio)
                  model[ai][63] = 1'b0;
            end
         end
         default: begin
            if (id < 8192 && eoi_mode) begin
               if (!afound) m_cnt = (m_cnt + 1) % (1 << CW);
               else model[ai][63] = 1'b0;
            end
         end
      endcase
      set_cnt = 0; drop_cnt = 0;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_grp = g; req_id = id;
      @(negedge clk);
      req_valid = 1'b0; lat = 1;
      while (!rsp_done && lat < 100) begin @(negedge clk); lat++; end
      #1;
      chk(lat == N + 2, "R10 latency", 64'(lat), 64'(N + 2));
      chk(rsp_id == exp_id, {tag, " id"}, 64'(rsp_id), 64'(exp_id));
      chk(set_cnt == exp_set && (exp_set == 0 || (set_lvl_seen == exp_lvl && set_grp_seen == g)),
          "R5 tracker set", 64'(set_cnt), 64'(exp_set));
      chk(drop_cnt == exp_drop, "R6 tracker drop", 64'(drop_cnt), 64'(exp_drop));
      chk(int'(eoi_count) == m_cnt, {tag, " count"}, 64'(eoi_count), 64'(m_cnt));
      mism = 0;
      for (int i = 0; i < N; i++) begin
         lr_rd_idx = IW'(i); #1;
         if (lr_rd_data != model[i]) begin
            mism = 1;
            chk(0, {tag, " entry"}, lr_rd_data, model[i]);
         end
      end
      if (!mism) chk(1, tag, 0, 0);
   endtask

   function automatic logic [31:0] rnd_vid();
      case ($urandom % 8)
         0: return 32'd1019;
         1: return 32'd1020;
         2: return 32'd8192;
         3: return 32'd8200;
         default: return 32'($urandom % 12);
      endcase
   endfunction

   function automatic logic [7:0] rnd_prio();
      return ($urandom % 6 == 0) ? 8'hFF : 8'(($urandom % 8) * 32 + ($urandom % 4) * 8);
   endfunction

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < N; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rsp_done == 0 && eoi_count == 0 && apr_set == 0 && apr_drop == 0,
          "R10 reset", {rsp_done, apr_set, apr_drop, 32'(eoi_count)}, 0);
      lr_rd_idx = 0; #1;
      chk(lr_rd_data == 0, "R1 reset entry", lr_rd_data, 0);

      // R3: equal priorities, lowest index wins
      lr_used = 4;
      load(0, mk(5, 8'h40, 1, 2'b01));
      load(1, mk(6, 8'h40, 1, 2'b01));
      load(2, mk(7, 8'h60, 1, 2'b01));
      load(3, mk(9, 8'hFF, 1, 2'b01));
      load(4, mk(11, 8'h10, 1, 2'b01));
      do_op(2'd1, 1, 0, "R3");
      chk(rsp_id == 5, "R3 tie", 64'(rsp_id), 5);
      // R1: pending+active and out-of-range entries skipped
      load(0, mk(5, 8'h40, 1, 2'b11));
      do_op(2'd1, 1, 0, "R1");
      chk(rsp_id == 6, "R1 skip", 64'(rsp_id), 6);
      // R2: group disabled
      grp1_en = 0;
      do_op(2'd1, 1, 0, "R2");
      chk(rsp_id == SPUR, "R2 disabled", 64'(rsp_id), SPUR);
      grp1_en = 1;
      // R4: mask equal to priority
      prio_mask = 8'h40;
      do_op(2'd0, 1, 0, "R4");
      chk(rsp_id == SPUR, "R4 mask", 64'(rsp_id), SPUR);
      prio_mask = 8'hFF;
      // R5: message-based ID gets no active state
      load(3, mk(8200, 8'h08, 1, 2'b01));
      do_op(2'd0, 1, 0, "R5");
      chk(rsp_id == 8200, "R5 lpi", 64'(rsp_id), 8200);
      do_op(2'd0, 1, 0, "R5");
      chk(rsp_id == 6, "R5 spi", 64'(rsp_id), 6);
      // R6/R7: EOI miss counts, mode 1 does not
      do_op(2'd2, 1, 99, "R7");
      eoi_mode = 1;
      do_op(2'd2, 1, 6, "R6");
      do_op(2'd3, 1, 6, "R8");
      eoi_mode = 0;
      do_op(2'd3, 1, 7, "R8");

      // Random phase
      for (int t = 0; t < 320; t++) begin
         if (t % 8 == 0) begin
            lr_used = (IW + 1)'($urandom % (N + 1));
            for (int i = 0; i < N; i++)
               load(i, mk(rnd_vid(), rnd_prio(), 1'($urandom), 2'($urandom)));
         end
         grp0_en   = ($urandom % 5) != 0;
         grp1_en   = ($urandom % 5) != 0;
         eoi_mode  = 1'($urandom);
         bpr0      = 3'($urandom % 4);
         bpr1      = 3'($urandom % 4);
         prio_mask = ($urandom % 3 == 0) ? 8'($urandom) : 8'hFF;
         run_prio  = ($urandom % 2 == 0) ? 8'hFF : 8'($urandom);
         begin
            int k;
            logic g;
            logic [31:0] id;
            k  = $urandom % N;
            g  = 1'($urandom);
            id = ($urandom % 4 == 0) ? rnd_vid() : model[k][31:0];
            drop_prio = ($urandom % 2 == 0) ? tb_pre(model[k][55:48], g) : 8'($urandom);
            do_op(2'($urandom), g, id, "");
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule